// File: doc/BRIEF.md
# Timed Bidirectional Motor Sequencer

This block controls an H-bridge motor driver through two lines: a brake line that is active low, and a direction level. One press of a momentary push button starts one fixed cycle. The motor runs forward for one phase, is held by the brake for one phase, runs in reverse for one phase, and then returns to a braked idle state. It stays there until the next press.

Each phase lasts `CLK_HZ * PHASE_SECONDS` clock cycles, so the same RTL can run ten-second phases on silicon and phases of a few cycles in simulation. The button input is raw and may bounce. The block passes it through a two-flop synchronizer and a counter-based debouncer, and only the debounced press edge can start a cycle. A `busy` output shows that a cycle is in progress.

Top module: `motor_seq_top`

## Requirements
- R1: During synchronous reset (`rst` high) and afterwards until an accepted press, the block is idle: `brake_n`=0 (brake engaged), `dir`=0, `busy`=0.
- R2: An accepted press starts the forward run: `brake_n`=1, `dir`=0 (0 = forward level), `busy`=1. `busy` first reads 1 on the (`DEBOUNCE_CYCLES`+3)-th clock edge after `btn_raw` goes high.
- R3: Forward run, brake pause and reverse run each last exactly `CLK_HZ*PHASE_SECONDS` cycles.
- R4: During the brake pause, `brake_n`=0, `dir`=1 (1 = reverse level) and `busy`=1.
- R5: During the reverse run, `brake_n`=1, `dir`=1 and `busy`=1. After it, the block returns to idle (`brake_n`=0, `dir`=0, `busy`=0).
- R6: A button level counts only after `DEBOUNCE_CYCLES` consecutive equal synchronized samples. A shorter high pulse starts nothing.
- R7: Holding the button down starts only one cycle. No new cycle starts while it stays held after the cycle ends.
- R8: Presses that arrive while `busy`=1 are ignored and not queued. The running cycle keeps its timing, and the block stays idle once the cycle ends.
- R9: `dir` never changes on the cycle in which `brake_n` rises. A run phase never begins together with a direction change.
- R10: If `rst` is high at a clock edge, the block is idle after that edge, whatever phase it was in. It does not resume the interrupted cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_raw | input | 1 | Raw momentary button level, asynchronous, high = pressed |
| brake_n | output | 1 | Brake control, low = brake engaged |
| dir | output | 1 | Direction level, 0 = forward, 1 = reverse |
| busy | output | 1 | High from the accepted press until the return to idle |

## Verification
The bench builds the block with `CLK_HZ`=4 and `PHASE_SECONDS`=2, so each phase is 8 cycles, and with `DEBOUNCE_CYCLES`=3, so the press-to-busy latency is 6 cycles. With these values a whole cycle fits in about thirty clocks. Every cycle of every phase can therefore be compared with the expected brake and direction levels, including the exact phase boundaries and the edge where `brake_n` rises. The short debounce window means pulses one cycle shorter than the limit and one cycle longer can both be tried. It also means a button held past the end of a full cycle, presses during the brake pause, and a reset in the middle of the reverse run all fit in a short run.

// File: rtl/motor_seq_pkg.sv
package motor_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FWD   = 2'd1,
    PH_BRAKE = 2'd2,
    PH_REV   = 2'd3
  } phase_e;

  // Number of clock cycles in one timed phase.
  function automatic longint unsigned phase_cycles(longint unsigned hz,
                                                   longint unsigned secs);
    return hz * secs;
  endfunction

  // Bridge drive for a phase, packed as {brake_n, dir}.
  function automatic logic [1:0] bridge_drive(phase_e ph);
    case (ph)
      PH_FWD:   return 2'b10;
      PH_BRAKE: return 2'b01;
      PH_REV:   return 2'b11;
      default:  return 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/btn_conditioner.sv
module btn_conditioner #(
  parameter int unsigned DEBOUNCE_CYCLES = 1_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_raw,
  output logic press
);
  localparam int unsigned DW = $clog2(DEBOUNCE_CYCLES + 1);
  localparam logic [DW-1:0] LIM = DW'(DEBOUNCE_CYCLES - 1);

  logic          sync_a, sync_b;
  logic          level, level_d;
  logic [DW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_a  <= 1'b0;
      sync_b  <= 1'b0;
      level   <= 1'b0;
      level_d <= 1'b0;
      cnt     <= '0;
    end else begin
      sync_a  <= btn_raw;
      sync_b  <= sync_a;
      level_d <= level;
      if (sync_b == level) begin
        cnt <= '0;
      end else if (cnt == LIM) begin
        level <= sync_b;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign press = level & ~level_d;

  // R7: a held level gives a single press pulse
  p_press_single_r7: assert property (@(posedge clk) disable iff (rst)
    press |=> !press);

  // R6: debounced level only rises after the synchronizer shows high
  p_level_follows_sync_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(level) |-> $past(sync_b));

endmodule

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter longint unsigned PHASE_LEN = 500_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int unsigned CW = (PHASE_LEN > 1) ? $clog2(PHASE_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(PHASE_LEN - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run || done) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  assign done = run && (cnt == LAST);

  // R3: every phase starts counting from zero
  p_fresh_phase_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(run) || $past(done)) |-> cnt == '0);

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import motor_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   press,
  input  logic   done,
  output phase_e state,
  output logic   brake_n,
  output logic   dir,
  output logic   busy
);
  phase_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      PH_IDLE:  if (press) nxt = PH_FWD;
      PH_FWD:   if (done)  nxt = PH_BRAKE;
      PH_BRAKE: if (done)  nxt = PH_REV;
      PH_REV:   if (done)  nxt = PH_IDLE;
      default:             nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= PH_IDLE;
    else     state <= nxt;
  end

  assign {brake_n, dir} = bridge_drive(state);
  assign busy = (state != PH_IDLE);

  // R8: a running phase only moves on at timer expiry; presses are ignored
  p_hold_until_done_r8: assert property (@(posedge clk) disable iff (rst)
    (state != PH_IDLE && !done) |=> state == $past(state));

  // R10: reset brings the sequencer home from any phase
  p_reset_home_r10: assert property (@(posedge clk)
    rst |=> state == PH_IDLE);

endmodule

// File: rtl/motor_seq_top.sv
module motor_seq_top
  import motor_seq_pkg::*;
#(
  parameter longint unsigned CLK_HZ          = 50_000_000,
  parameter longint unsigned PHASE_SECONDS   = 10,
  parameter int unsigned     DEBOUNCE_CYCLES = 1_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_raw,
  output logic brake_n,
  output logic dir,
  output logic busy
);
  localparam longint unsigned PHASE_LEN = phase_cycles(CLK_HZ, PHASE_SECONDS);

  // Internal events brought out as named wires.
  logic   press_evt;
  logic   phase_done;
  phase_e phase;

  btn_conditioner #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) u_btn (
    .clk     (clk),
    .rst     (rst),
    .btn_raw (btn_raw),
    .press   (press_evt)
  );

  phase_timer #(.PHASE_LEN(PHASE_LEN)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .run  (busy),
    .done (phase_done)
  );

  seq_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .press   (press_evt),
    .done    (phase_done),
    .state   (phase),
    .brake_n (brake_n),
    .dir     (dir),
    .busy    (busy)
  );

  // R1: whenever idle the brake is engaged
  p_idle_braked_r1: assert property (@(posedge clk)
    !busy |-> !brake_n);

  // R2: a cycle opens with a forward run
  p_start_forward_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> brake_n && !dir);

  // R4: braked time inside a cycle holds the reverse level
  p_pause_reverse_level_r4: assert property (@(posedge clk)
    (busy && !brake_n) |-> dir);

  // R5: a cycle closes out of the reverse run
  p_end_from_reverse_r5: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(rst)) |-> $past(brake_n) && $past(dir));

  // R9: no run starts together with a direction change
  p_dir_steady_on_run_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(brake_n) |-> $stable(dir));

endmodule

// File: tb/sim_motor_seq_top.sv
module sim_motor_seq_top;
  localparam int HZ   = 4;
  localparam int SECS = 2;
  localparam int DEB  = 3;
  localparam int P    = HZ * SECS;   // cycles per phase
  localparam int LAT  = DEB + 3;     // raw press to busy
  localparam int NV   = 5;
  localparam int HOLD  [NV] = '{1, 2, 3, 10, 40};
  localparam bit START [NV] = '{0, 0, 1, 1, 1};

  logic clk = 1'b0;
  logic rst, btn_raw;
  logic brake_n, dir, busy;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  motor_seq_top #(.CLK_HZ(HZ), .PHASE_SECONDS(SECS), .DEBOUNCE_CYCLES(DEB)) u0 (
    .clk(clk), .rst(rst), .btn_raw(btn_raw),
    .brake_n(brake_n), .dir(dir), .busy(busy)
  );

  task automatic chk(input string tag, input logic [2:0] got, input logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: {brake_n,dir,busy} got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [2:0] expect_at(int k);
    if (k < P)       return 3'b101;
    if (k < 2 * P)   return 3'b011;
    if (k < 3 * P)   return 3'b111;
    return 3'b000;
  endfunction

  // Called on the negedge where busy first reads 1.
  task automatic profile();
    logic prev_dir;
    prev_dir = 1'b0;
    for (int k = 0; k <= 3 * P; k++) begin
      if (k < P)          chk("R2 R3 forward", {brake_n, dir, busy}, expect_at(k));
      else if (k < 2 * P) chk("R3 R4 pause", {brake_n, dir, busy}, expect_at(k));
      else if (k < 3 * P) chk("R3 R5 reverse", {brake_n, dir, busy}, expect_at(k));
      else                chk("R5 back to idle", {brake_n, dir, busy}, expect_at(k));
      if (k == 2 * P) chk("R9 dir steady as run begins", {2'b00, dir}, {2'b00, prev_dir});
      prev_dir = dir;
      if (k < 3 * P) @(negedge clk);
    end
  endtask

  task automatic idle_for(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(tag, {brake_n, dir, busy}, 3'b000);
    end
  endtask

  task automatic press_and_watch(input int hold, input bit start);
    fork
      begin
        btn_raw = 1'b1;
        repeat (hold) @(negedge clk);
        btn_raw = 1'b0;
      end
      begin
        for (int i = 1; i < LAT; i++) begin
          @(negedge clk);
          chk("R2 R6 not yet started", {2'b00, busy}, 3'b000);
        end
        @(negedge clk);
        if (start) begin
          chk("R2 start latency", {brake_n, dir, busy}, 3'b101);
          profile();
          idle_for("R7 no repeat while held or after", 20);
        end else begin
          chk("R6 short pulse rejected", {brake_n, dir, busy}, 3'b000);
          idle_for("R6 short pulse rejected", 10);
        end
      end
    join
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    btn_raw = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 idle during reset", {brake_n, dir, busy}, 3'b000);
    rst = 1'b0;
    idle_for("R1 idle after reset", 4);

    // Vector table walk: pulse lengths against the debounce window.
    for (int v = 0; v < NV; v++) begin
      press_and_watch(HOLD[v], START[v]);
      idle_for("R6 R7 settle", 4);
    end

    // R8: presses during the brake pause are ignored, not queued.
    fork
      begin
        btn_raw = 1'b1;
        repeat (3) @(negedge clk);
        btn_raw = 1'b0;
        repeat (LAT - 3 + P + 2) @(negedge clk);
        btn_raw = 1'b1;
        repeat (5) @(negedge clk);
        btn_raw = 1'b0;
      end
      begin
        repeat (LAT) @(negedge clk);
        chk("R8 cycle started", {brake_n, dir, busy}, 3'b101);
        profile();
        idle_for("R8 busy press not queued", 20);
      end
    join

    // R10: reset in the middle of the reverse run.
    btn_raw = 1'b1;
    repeat (3) @(negedge clk);
    btn_raw = 1'b0;
    repeat (LAT - 3) @(negedge clk);
    chk("R10 started before reset", {brake_n, dir, busy}, 3'b101);
    repeat (2 * P + 3) @(negedge clk);
    chk("R10 in reverse before reset", {brake_n, dir, busy}, 3'b111);
    rst = 1'b1;
    @(negedge clk);
    chk("R10 idle after reset edge", {brake_n, dir, busy}, 3'b000);
    rst = 1'b0;
    idle_for("R10 no resume after reset", 3 * P);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule